// File: doc/BRIEF.md
# Load Switch Enable Controller

This block computes the enable levels for five power switches in a supply-and-interface chip: three high-side and two low-side. A latched control word holds the normal settings. An external PWM pin can drive the first high-side switch, and the control word takes priority over it. The third high-side switch has a periodic pulse mode that powers external wake-up circuits during low power. It counts ticks of the chip's internal cycle clock.

Several protection conditions can turn the switches off. Supply undervoltage lockout, chip reset and thermal shutdown turn off every switch. The watchdog undercurrent state turns off the two low-side switches only. The block also builds a 16-bit diagnosis word from the thermal, overload and undervoltage status inputs and from the low-side enable levels. The analog drivers, current limits and clamps sit outside the block and appear only as status inputs. All outputs are combinational in the inputs, except the pulse-mode counter, which is registered.

Top module: `load_switch_ctrl`

## Requirements
- R1: With no shutoff active, `hs1_on` is high when control bit 1 is set, or when control bit 11 is set and `pwm_in` is high. Otherwise it is low.
- R2: While control bit 1 is set, `hs1_on` stays high whatever the level of `pwm_in` and control bit 11.
- R3: With no shutoff active, `hs2_on` follows control bit 2, `ls1_on` follows bit 5 and `ls2_on` follows bit 6.
- R4: With no shutoff active, `hs3_on` depends on control bits 3 and 4. Bit 3 set with bit 4 clear gives continuously on. Bit 4 set with bit 3 clear gives off. Both clear gives off. Both set selects pulse mode.
- R5: In pulse mode, a counter advances by one on each clock that has `cyc_tick` high and wraps after `AT_PERIOD` counts. `hs3_on` is high while the counter is below `AT_ON`. The counter is 0 on the cycle the mode is entered, so the first pulse starts at once. It holds at 0 while the mode is not selected.
- R6: While `uv_lock` is high, all five enables are low, and diagnosis bit 3 is high. Diagnosis bit 3 equals `uv_lock` at all times.
- R7: While `rst_n` is low, all five enables are low and the pulse counter is cleared.
- R8: While `wd_undercur` is high, `ls1_on` and `ls2_on` are low. The high-side enables are unaffected.
- R9: While `therm_sd` is high, all five enables are low, and diagnosis bit 14 is high. Diagnosis bit 14 equals `therm_sd` at all times.
- R10: Diagnosis bit 0 equals `therm_warn` and bit 1 equals `hs1_ovl`. Bits 5 and 6 equal `ls1_on` and `ls2_on`. Bits 2, 4, 7 to 13 and 15 are 0.
- R11: The pulse counter keeps advancing while a shutoff masks `hs3_on`. After the shutoff clears, the pulse phase continues from the count reached.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low chip reset; forces all switches off |
| ctrl_word | input | 16 | Latched control word |
| pwm_in | input | 1 | External PWM level for high-side switch 1 |
| cyc_tick | input | 1 | One-clock pulse per internal cycle |
| uv_lock | input | 1 | Supply undervoltage lockout active |
| wd_undercur | input | 1 | Watchdog disabled by undercurrent function |
| therm_sd | input | 1 | Thermal shutdown |
| therm_warn | input | 1 | Thermal prewarning |
| hs1_ovl | input | 1 | Overload on high-side switch 1 |
| hs1_on | output | 1 | High-side switch 1 enable |
| hs2_on | output | 1 | High-side switch 2 enable |
| hs3_on | output | 1 | High-side switch 3 enable |
| ls1_on | output | 1 | Low-side switch 1 enable |
| ls2_on | output | 1 | Low-side switch 2 enable |
| diag | output | 16 | Diagnosis word |

## Verification
The bench builds the block with `AT_PERIOD` = 16 and `AT_ON` = 3. With these values three full pulse periods, including every wrap and the edge of each on-window, take under 50 cycles, and the bench checks each cycle against a counter it computes itself. The static behaviour is swept exhaustively: all 128 combinations of the seven control bits that matter, each crossed with every combination of the PWM pin and the three shutoff inputs. Further directed sequences cover leaving pulse mode and entering it again, ticks arriving with gaps, the counter running on under a shutoff, and reset in the middle of a period.

// File: rtl/load_switch_ctrl.sv
module load_switch_ctrl #(
  parameter int AT_PERIOD = 128,
  parameter int AT_ON     = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] ctrl_word,
  input  logic        pwm_in,
  input  logic        cyc_tick,
  input  logic        uv_lock,
  input  logic        wd_undercur,
  input  logic        therm_sd,
  input  logic        therm_warn,
  input  logic        hs1_ovl,
  output logic        hs1_on,
  output logic        hs2_on,
  output logic        hs3_on,
  output logic        ls1_on,
  output logic        ls2_on,
  output logic [15:0] diag
);
  localparam int CW = (AT_PERIOD > 1) ? $clog2(AT_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(AT_PERIOD - 1);
  localparam logic [CW-1:0] ONW  = CW'(AT_ON);

  logic [CW-1:0] at_cnt;
  logic          at_mode, kill_all, kill_ls, hs3_req;

  assign at_mode  = ctrl_word[3] & ctrl_word[4];
  assign kill_all = ~rst_n | uv_lock | therm_sd;
  assign kill_ls  = kill_all | wd_undercur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           at_cnt <= '0;
    else if (!at_mode)    at_cnt <= '0;
    else if (cyc_tick)    at_cnt <= (at_cnt == LAST) ? '0 : at_cnt + 1'b1;
  end

  always_comb begin
    unique case (ctrl_word[4:3])
      2'b01:   hs3_req = 1'b1;
      2'b11:   hs3_req = (at_cnt < ONW);
      default: hs3_req = 1'b0;
    endcase
  end

  assign hs1_on = ~kill_all & (ctrl_word[1] | (ctrl_word[11] & pwm_in));
  assign hs2_on = ~kill_all & ctrl_word[2];
  assign hs3_on = ~kill_all & hs3_req;
  assign ls1_on = ~kill_ls  & ctrl_word[5];
  assign ls2_on = ~kill_ls  & ctrl_word[6];

  assign diag = {1'b0, therm_sd, 7'b0, ls2_on, ls1_on, 1'b0, uv_lock, 1'b0, hs1_ovl, therm_warn};
endmodule

// File: rtl/load_switch_ctrl_chk.sv
module load_switch_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] ctrl_word,
  input logic        uv_lock,
  input logic        wd_undercur,
  input logic        therm_sd,
  input logic        hs1_on,
  input logic        hs2_on,
  input logic        hs3_on,
  input logic        ls1_on,
  input logic        ls2_on,
  input logic [15:0] diag
);
  logic any_on;
  assign any_on = hs1_on | hs2_on | hs3_on | ls1_on | ls2_on;

  // R2
  hs1_ctrl_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[1] && !uv_lock && !therm_sd) |-> hs1_on);
  // R4
  hs3_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[3] && !ctrl_word[4] && !uv_lock && !therm_sd) |-> hs3_on);
  // R5
  at_first_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[3] && ctrl_word[4] && !($past(ctrl_word[3]) && $past(ctrl_word[4]))
     && !uv_lock && !therm_sd) |-> hs3_on);
  // R6
  uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_lock |-> (!any_on && diag[3]));
  // R7
  rst_off_chk: assert property (@(posedge clk) !rst_n |-> !any_on);
  // R8
  ls_undercur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_undercur |-> (!ls1_on && !ls2_on));
  // R9
  tsd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    therm_sd |-> (!any_on && diag[14]));
  // R10
  diag_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (diag[5] == ls1_on) && (diag[6] == ls2_on));
endmodule

bind load_switch_ctrl load_switch_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .uv_lock(uv_lock),
  .wd_undercur(wd_undercur), .therm_sd(therm_sd), .hs1_on(hs1_on),
  .hs2_on(hs2_on), .hs3_on(hs3_on), .ls1_on(ls1_on), .ls2_on(ls2_on),
  .diag(diag)
);

// File: tb/load_switch_ctrl_tb.sv
module load_switch_ctrl_tb;
  localparam int P  = 16;
  localparam int ON = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] ctrl_word = '0;
  logic pwm_in = 0, cyc_tick = 0, uv_lock = 0, wd_undercur = 0, therm_sd = 0;
  logic therm_warn = 0, hs1_ovl = 0;
  logic hs1_on, hs2_on, hs3_on, ls1_on, ls2_on;
  logic [15:0] diag;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  load_switch_ctrl #(.AT_PERIOD(P), .AT_ON(ON)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .pwm_in(pwm_in),
    .cyc_tick(cyc_tick), .uv_lock(uv_lock), .wd_undercur(wd_undercur),
    .therm_sd(therm_sd), .therm_warn(therm_warn), .hs1_ovl(hs1_ovl),
    .hs1_on(hs1_on), .hs2_on(hs2_on), .hs3_on(hs3_on), .ls1_on(ls1_on),
    .ls2_on(ls2_on), .diag(diag)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] diag_exp(input logic tsd, input logic l2, input logic l1,
                                           input logic uv, input logic ov, input logic tw);
    diag_exp = '0;
    diag_exp[14] = tsd; diag_exp[6] = l2; diag_exp[5] = l1;
    diag_exp[3] = uv; diag_exp[1] = ov; diag_exp[0] = tw;
  endfunction

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic e1, e2, e3, e4, e5, ka, kl;
    int k;
    // R7: reset state with everything requested
    ctrl_word = 16'hFFFF; pwm_in = 1;
    @(negedge clk); #1;
    chk("R7 reset outputs", {11'b0, hs1_on, hs2_on, hs3_on, ls1_on, ls2_on}, 16'h0);
    chk("R10 reset diag", diag, 16'h0);
    ctrl_word = '0; pwm_in = 0;
    @(negedge clk); rst_n = 1;

    // exhaustive static sweep, no ticks: R1 R2 R3 R4 R6 R8 R9 R10
    for (int i = 0; i < 2048; i++) begin
      @(negedge clk);
      ctrl_word = '0;
      ctrl_word[1] = i[0]; ctrl_word[2] = i[1]; ctrl_word[3] = i[2];
      ctrl_word[4] = i[3]; ctrl_word[5] = i[4]; ctrl_word[6] = i[5];
      ctrl_word[11] = i[6];
      pwm_in = i[7]; uv_lock = i[8]; wd_undercur = i[9]; therm_sd = i[10];
      therm_warn = i[0] ^ i[9]; hs1_ovl = i[3] ^ i[10];
      #2;
      ka = i[8] | i[10];
      kl = ka | i[9];
      e1 = !ka && (i[0] || (i[6] && i[7]));
      e2 = !ka && i[1];
      e3 = !ka && (i[2] && !i[3] ? 1'b1 : (i[2] && i[3]));
      e4 = !kl && i[4];
      e5 = !kl && i[5];
      chk(i[0] ? "R2 hs1 ctrl priority" : "R1 hs1 pwm path", {15'b0, hs1_on}, {15'b0, e1});
      chk("R3 hs2/ls1/ls2 (R6 R8 R9 shutoffs)", {13'b0, hs2_on, ls1_on, ls2_on}, {13'b0, e2, e4, e5});
      chk("R4 hs3 mode select", {15'b0, hs3_on}, {15'b0, e3});
      chk("R10 diag word (R6 R9 bits)", diag,
          diag_exp(therm_sd, e5, e4, uv_lock, hs1_ovl, therm_warn));
    end

    // R5: pulse mode over three periods, tick every cycle
    @(negedge clk);
    uv_lock = 0; wd_undercur = 0; therm_sd = 0; ctrl_word = '0;
    @(negedge clk);
    ctrl_word = 16'h0018; cyc_tick = 1;
    for (k = 0; k < 3 * P; k++) begin
      #2;
      chk("R5 pulse pattern", {15'b0, hs3_on}, {15'b0, logic'((k % P) < ON)});
      @(negedge clk);
    end
    // leave mid-period and re-enter: restart at 0
    cyc_tick = 1;
    ctrl_word = 16'h0008; #2;
    chk("R4 hs3 steady on", {15'b0, hs3_on}, 16'h1);
    @(negedge clk); ctrl_word = 16'h0010; #2;
    chk("R4 bit4 alone off", {15'b0, hs3_on}, 16'h0);
    @(negedge clk); ctrl_word = 16'h0018; #2;
    chk("R5 re-entry first pulse", {15'b0, hs3_on}, 16'h1);
    // ticks with gaps: count advances only on tick cycles
    k = 0;
    for (int c = 0; c < 24; c++) begin
      @(negedge clk);
      k = k + 1;
      cyc_tick = (c % 3 == 0);
      #2;
      chk("R5 gapped ticks", {15'b0, hs3_on}, {15'b0, logic'((k % P) < ON)});
      if (!cyc_tick) k = k - 1;
      else k = k;
    end
    // R11: shutoff masks output, counter runs on
    @(negedge clk); cyc_tick = 0;
    @(negedge clk); ctrl_word = '0;
    @(negedge clk); ctrl_word = 16'h0018; cyc_tick = 1; uv_lock = 1; #2;
    chk("R6 uv masks pulse", {15'b0, hs3_on}, 16'h0);
    for (k = 1; k < P + 4; k++) begin
      @(negedge clk);
      if (k == 6) uv_lock = 0;
      #2;
      chk("R11 phase kept across shutoff", {15'b0, hs3_on},
          {15'b0, logic'(!uv_lock && ((k % P) < ON))});
    end
    // R7: reset mid-period clears counter
    @(negedge clk); cyc_tick = 0; #2;
    chk("R5 before reset off-window", {15'b0, hs3_on}, {15'b0, logic'((k % P) < ON)});
    rst_n = 0; #1;
    chk("R7 reset forces off", {15'b0, hs3_on}, 16'h0);
    @(negedge clk); rst_n = 1; #2;
    chk("R7 counter cleared by reset", {15'b0, hs3_on}, 16'h1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule